// File: doc/BRIEF.md
# Lazy Instruction Predictor Table

This block predicts, early in the pipeline, whether an instruction is likely to sit in the issue queue for a long time. Such an instruction is called lazy. A scheduler can use the one-bit prediction to wake that entry less often, or to slow the front end. The block is a small direct-mapped table indexed by program counter. Each slot holds a valid bit, an address tag and a two-bit saturating confidence counter.

There are two ports. The lookup port accepts a program counter at dispatch and returns a prediction one cycle later. The training port receives, when an instruction issues, its program counter and the number of cycles it waited. Lazy instructions build up confidence in their slot. An instruction that turns out not to be lazy removes its slot outright.

Both ports use valid/ready. The training port never back-pressures: its ready output is always high. The lookup port has a single response register. A new lookup is accepted only when that register is empty or is being drained in the same cycle (`lk_ready = !rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the response holds its value unchanged.

Top module: `lazy_pred_table`

## Requirements
- R1: After a synchronous reset every slot is invalid, so every lookup answers not-lazy (`rsp_lazy`=0).
- R2: A trained instruction is lazy only when its delay is strictly greater than 10 cycles. A delay of exactly 10 is treated as not lazy.
- R3: A lazy training that misses its slot allocates the slot with the counter at 1. One or two lazy trainings alone do not produce a lazy prediction.
- R4: A lazy training that hits its slot increments the counter, saturating at 3. A lookup predicts lazy only for a valid tag hit with the counter at 3. Further lazy trainings keep the prediction at 1.
- R5: A non-lazy training that hits its slot invalidates it. Three fresh lazy trainings are then needed before the prediction returns.
- R6: A non-lazy training that misses (wrong tag, or slot invalid) leaves the table unchanged.
- R7: The slot index is PC[7:2]. PC[1:0] are ignored, and PC[31:8] form the tag. A different tag at the same index misses, and a lazy miss there overwrites the previous occupant.
- R8: When a lookup and a training land on the same slot in the same cycle, the lookup answers from the contents before the training.
- R9: The lookup response appears the cycle after acceptance. `lk_ready` equals `!rsp_valid || rsp_ready`. A stalled response keeps `rsp_valid` high and `rsp_lazy` stable.
- R10: `upd_ready` is always high, so a training is taken in every cycle in which `upd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_pc | input | 32 | Program counter to look up |
| rsp_valid | output | 1 | Prediction valid |
| rsp_ready | input | 1 | Consumer takes the prediction |
| rsp_lazy | output | 1 | 1 = predicted lazy |
| upd_valid | input | 1 | Training request valid |
| upd_ready | output | 1 | Training accepted (always 1) |
| upd_pc | input | 32 | Program counter of the issuing instruction |
| upd_delay | input | 8 | Cycles the instruction waited before issue |

## Verification
The embedded properties assume that the requester holds `lk_pc` steady until `lk_ready` is seen. They also assume that `upd_pc` and `upd_delay` carry known values whenever `upd_valid` is high, because the training decode is checked on every valid cycle. The stimulus drives all inputs only on the falling edge. It holds each lookup until it is accepted and keeps the training fields defined whenever the training valid is raised. Back-pressure is applied only by dropping `rsp_ready`, which the properties treat as legal in any cycle.

// File: rtl/lazy_pred_pkg.sv
package lazy_pred_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_ALLOC = 2'd1,
    ACT_BUMP  = 2'd2,
    ACT_DROP  = 2'd3
  } lp_act_e;
endpackage

// File: rtl/lp_pc_split.sv
module lp_pc_split #(
  parameter int PC_W  = 32,
  parameter int OFS_W = 2,
  parameter int IDX_W = 6,
  localparam int TAG_W = PC_W - IDX_W - OFS_W
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag,
  output logic [OFS_W-1:0] ofs
);
  assign ofs = pc[OFS_W-1:0];
  assign idx = pc[OFS_W +: IDX_W];
  assign tag = pc[PC_W-1 -: TAG_W];
endmodule

// File: rtl/lp_store.sv
module lp_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 24,
  parameter int CNT_W = 2,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  output logic [CNT_W-1:0] rd_cnt,
  input  logic [IDX_W-1:0] up_idx,
  output logic             up_vld,
  output logic [TAG_W-1:0] up_tag,
  output logic [CNT_W-1:0] up_cnt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [CNT_W-1:0] wr_cnt
);
  logic             vld_q [ENTRIES];
  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [CNT_W-1:0] cnt_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst)         vld_q[e] <= 1'b0;
      else if (hit_wr) vld_q[e] <= wr_vld;
    end

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        tag_q[e] <= wr_tag;
        cnt_q[e] <= wr_cnt;
      end
    end
  end

  assign rd_vld = vld_q[rd_idx];
  assign rd_tag = tag_q[rd_idx];
  assign rd_cnt = cnt_q[rd_idx];
  assign up_vld = vld_q[up_idx];
  assign up_tag = tag_q[up_idx];
  assign up_cnt = cnt_q[up_idx];

  // R4
  live_cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_vld) |-> (wr_cnt != '0));
endmodule

// File: rtl/lp_train.sv
module lp_train
  import lazy_pred_pkg::*;
#(
  parameter int TAG_W      = 24,
  parameter int CNT_W      = 2,
  parameter int DELAY_W    = 8,
  parameter int LAZY_LIMIT = 10,
  localparam logic [CNT_W-1:0] CNT_TOP = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd_fire,
  input  logic [DELAY_W-1:0] upd_delay,
  input  logic [TAG_W-1:0]   upd_tag,
  input  logic               up_vld,
  input  logic [TAG_W-1:0]   up_tag,
  input  logic [CNT_W-1:0]   up_cnt,
  output logic               wr_en,
  output logic               wr_vld,
  output logic [TAG_W-1:0]   wr_tag,
  output logic [CNT_W-1:0]   wr_cnt
);
  logic    is_lazy;
  logic    slot_hit;
  lp_act_e act;

  assign is_lazy  = upd_delay > DELAY_W'(LAZY_LIMIT);
  assign slot_hit = up_vld && (up_tag == upd_tag);

  always_comb begin
    act = ACT_KEEP;
    if (upd_fire) begin
      if (is_lazy) act = slot_hit ? ACT_BUMP : ACT_ALLOC;
      else if (slot_hit) act = ACT_DROP;
    end
  end

  always_comb begin
    wr_en  = 1'b0;
    wr_vld = 1'b0;
    wr_tag = upd_tag;
    wr_cnt = up_cnt;
    unique case (act)
      ACT_ALLOC: begin
        wr_en  = 1'b1;
        wr_vld = 1'b1;
        wr_cnt = CNT_W'(1);
      end
      ACT_BUMP: begin
        wr_en  = 1'b1;
        wr_vld = 1'b1;
        wr_cnt = (up_cnt == CNT_TOP) ? up_cnt : up_cnt + CNT_W'(1);
      end
      ACT_DROP: begin
        wr_en  = 1'b1;
        wr_vld = 1'b0;
      end
      default: ;
    endcase
  end

  // R3
  alloc_new_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && is_lazy && !slot_hit) |-> (wr_en && wr_vld && wr_cnt == CNT_W'(1)));
  // R5
  drop_on_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !is_lazy && slot_hit) |-> (wr_en && !wr_vld));
  // R6
  fast_miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !is_lazy && !slot_hit) |-> !wr_en);
  // R4
  bump_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && is_lazy && slot_hit) |-> (wr_cnt >= up_cnt && wr_cnt != '0));
endmodule

// File: rtl/lazy_pred_table.sv
module lazy_pred_table #(
  parameter int PC_W       = 32,
  parameter int OFS_W      = 2,
  parameter int IDX_W      = 6,
  parameter int CNT_W      = 2,
  parameter int DELAY_W    = 8,
  parameter int LAZY_LIMIT = 10,
  localparam int TAG_W = PC_W - IDX_W - OFS_W,
  localparam logic [CNT_W-1:0] CNT_TOP = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [PC_W-1:0]    lk_pc,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_lazy,
  input  logic               upd_valid,
  output logic               upd_ready,
  input  logic [PC_W-1:0]    upd_pc,
  input  logic [DELAY_W-1:0] upd_delay
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag_in;
  logic [OFS_W-1:0] lk_ofs, up_ofs;
  logic             unused_ofs;

  logic             rd_vld, up_vld;
  logic [TAG_W-1:0] rd_tag, up_tag;
  logic [CNT_W-1:0] rd_cnt, up_cnt;

  logic             wr_en, wr_vld;
  logic [TAG_W-1:0] wr_tag;
  logic [CNT_W-1:0] wr_cnt;

  logic lk_fire, upd_fire, pred_now;
  logic rsp_valid_q, rsp_lazy_q;

  lp_pc_split #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_lk_split (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag), .ofs(lk_ofs));

  lp_pc_split #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_up_split (
    .pc(upd_pc), .idx(up_idx), .tag(up_tag_in), .ofs(up_ofs));

  assign unused_ofs = ^{lk_ofs, up_ofs};

  lp_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_cnt(rd_cnt),
    .up_idx(up_idx), .up_vld(up_vld), .up_tag(up_tag), .up_cnt(up_cnt),
    .wr_en(wr_en), .wr_idx(up_idx), .wr_vld(wr_vld), .wr_tag(wr_tag), .wr_cnt(wr_cnt));

  lp_train #(.TAG_W(TAG_W), .CNT_W(CNT_W), .DELAY_W(DELAY_W), .LAZY_LIMIT(LAZY_LIMIT)) u_train (
    .clk(clk), .rst(rst),
    .upd_fire(upd_fire), .upd_delay(upd_delay), .upd_tag(up_tag_in),
    .up_vld(up_vld), .up_tag(up_tag), .up_cnt(up_cnt),
    .wr_en(wr_en), .wr_vld(wr_vld), .wr_tag(wr_tag), .wr_cnt(wr_cnt));

  assign upd_ready = 1'b1;
  assign upd_fire  = upd_valid && upd_ready;
  assign lk_ready  = !rsp_valid_q || rsp_ready;
  assign lk_fire   = lk_valid && lk_ready;
  assign pred_now  = rd_vld && (rd_tag == lk_tag) && (rd_cnt == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst)            rsp_valid_q <= 1'b0;
    else if (lk_fire)   rsp_valid_q <= 1'b1;
    else if (rsp_ready) rsp_valid_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          rsp_lazy_q <= 1'b0;
    else if (lk_fire) rsp_lazy_q <= pred_now;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_lazy  = rsp_lazy_q;

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_lazy)));
  // R9
  rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |=> rsp_valid);
  // R9
  no_accept_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !lk_ready);
endmodule

// File: tb/sim_lazy_pred_table.sv
`timescale 1ns/100ps
module sim_lazy_pred_table;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_pc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_lazy;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [31:0] upd_pc = '0;
  logic [7:0]  upd_delay = '0;

  int checks = 0;
  int fails  = 0;
  bit expq[$];
  string reqq[$];

  localparam logic [31:0] PA = 32'h0000_1040; // index 16, tag 0x10
  localparam logic [31:0] PB = 32'h0000_2040; // index 16, tag 0x20
  localparam logic [31:0] PA2 = 32'h0000_1041; // alias of PA via PC[1:0]
  localparam logic [31:0] PC3 = 32'h0000_1044; // index 17

  always #2.5 clk = ~clk;

  lazy_pred_table u0 (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_lazy(rsp_lazy),
    .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_pc(upd_pc), .upd_delay(upd_delay));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops an expectation on every response transfer
  always @(posedge clk) begin
    if (!rst && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R9", "unexpected response", 1, 0);
      end else begin
        automatic bit e = expq.pop_front();
        automatic string r = reqq.pop_front();
        chk(rsp_lazy == e, r, "prediction", rsp_lazy, e);
      end
    end
  end

  task automatic lookup(input logic [31:0] pc, input bit exp, input string req);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_pc    = pc;
    forever begin
      @(posedge clk);
      if (lk_ready) break;
    end
    expq.push_back(exp);
    reqq.push_back(req);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic train(input logic [31:0] pc, input logic [7:0] d);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_pc    = pc;
    upd_delay = d;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    rst = 1'b0;
    // R10
    chk(upd_ready == 1'b1, "R10", "upd_ready", upd_ready, 1);
    lookup(PA, 1'b0, "R1");
    lookup(PB, 1'b0, "R1");

    // R2: delay 10 is not lazy, so two lazy trainings give count 2 only
    train(PA, 8'd10);
    train(PA, 8'd11);
    train(PA, 8'd11);
    lookup(PA, 1'b0, "R3");
    // R2, R4: third lazy training reaches 3
    train(PA, 8'd11);
    lookup(PA, 1'b1, "R2");
    lookup(PA2, 1'b1, "R7");
    lookup(PB, 1'b0, "R7");

    // R4: saturation
    train(PA, 8'd200);
    train(PA, 8'd50);
    chk(upd_ready == 1'b1, "R10", "upd_ready", upd_ready, 1);
    lookup(PA, 1'b1, "R4");

    // R6: non-lazy miss at same index leaves the slot alone
    train(PB, 8'd2);
    lookup(PA, 1'b1, "R6");

    // R8: lookup and invalidating training in the same cycle
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = PA;
    upd_valid = 1'b1; upd_pc = PA; upd_delay = 8'd3;
    @(posedge clk);
    chk(lk_ready == 1'b1, "R9", "lk_ready idle", lk_ready, 1);
    expq.push_back(1'b1); reqq.push_back("R8");
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    // R5: slot removed
    lookup(PA, 1'b0, "R5");
    train(PA, 8'd12);
    lookup(PA, 1'b0, "R5");
    train(PA, 8'd12);
    train(PA, 8'd12);
    lookup(PA, 1'b1, "R5");

    // R7: lazy miss at same index overwrites
    train(PB, 8'd99);
    lookup(PA, 1'b0, "R7");
    lookup(PB, 1'b0, "R3");
    train(PB, 8'd99);
    train(PB, 8'd99);
    lookup(PB, 1'b1, "R7");

    // other index independent
    train(PC3, 8'd40);
    train(PC3, 8'd40);
    train(PC3, 8'd40);
    lookup(PC3, 1'b1, "R7");
    lookup(PB, 1'b1, "R7");
    drain();

    // R9: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    lookup(PB, 1'b1, "R9");
    chk(rsp_valid == 1'b1, "R9", "rsp_valid stalled", rsp_valid, 1);
    chk(lk_ready == 1'b0, "R9", "lk_ready stalled", lk_ready, 0);
    lk_valid = 1'b1; lk_pc = PA;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R9", "rsp_valid held", rsp_valid, 1);
      chk(rsp_lazy == 1'b1, "R9", "rsp_lazy held", rsp_lazy, 1);
      chk(lk_ready == 1'b0, "R9", "lk_ready held low", lk_ready, 0);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    chk(lk_ready == 1'b1, "R9", "lk_ready on drain", lk_ready, 1);
    expq.push_back(1'b0); reqq.push_back("R9");
    @(negedge clk);
    lk_valid = 1'b0;
    drain();
    chk(expq.size() == 0, "R9", "pending responses", expq.size(), 0);

    // R1: reset again clears trained slots
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    rst = 1'b0;
    lookup(PB, 1'b0, "R1");
    lookup(PC3, 1'b0, "R1");
    drain();
    chk(expq.size() == 0, "R9", "pending responses at end", expq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule